// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is a clocked model of the control logic that sits behind the pins of a byte-wide parallel NOR flash. It samples active-low chip-select, write and output strobes together with an address bus and a byte-wide data bus. From the stream of bus write cycles it picks out the unlock patterns that guard the destructive operations. It then programs one byte, erases one aligned sector, or erases the whole array held in a small internal memory.

Once an operation has been accepted the block stays busy for a number of clock cycles set by a parameter for each operation kind. During that time reads return status bits instead of array contents, and bus writes are dropped. The strobes are sampled on the clock, so each strobe level has to be held for at least one clock cycle. A write cycle takes its address when the second of the two write strobes goes low and its data when the first of them goes high again. Sectors are 2^SECTOR_W bytes, which is 4 KB when SECTOR_W is 12. The array holds SECTORS sectors, SECTORS is a power of two and at least 2, and addresses above the array alias onto it. Command addresses are compared on the low 15 address bits.

Top module: `pflash_cmd_decoder`

## Requirements
- R1: A bus write cycle exists only while ceN and weN are both low; a weN pulse with ceN high has no effect. The address is taken when the later of the two strobes falls, and the data when the earlier of the two rises, so bus changes outside those instants are not used.
- R2: dataOutEn is 1 exactly when ceN and oeN are both low; when idle, dataOut then shows the array byte at addr.
- R3: The write sequence AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then data D at address X, leaves the byte at X equal to its old value AND D.
- R4: The busy interval begins at the clock edge that sees the final write cycle end and lasts PROG_CYC, SECT_CYC or CHIP_CYC clock cycles for program, sector erase and chip erase; a read held across it shows status for that many cycles and array data afterwards.
- R5: The sequence AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 30h at any address sets every byte of the aligned sector holding that address to FFh and leaves other sectors unchanged.
- R6: The same five opening cycles followed by 10h at 5555h set every byte of the array to FFh.
- R7: While busy, a read returns a status byte: bit 7 is the inverse of bit 7 of the byte being programmed, or 0 during either erase; bit 6 is 0 on the first read of the operation and inverts after each completed read; bits 5 to 0 are 0. Bit 6 holds steady within one read.
- R8: Bus write cycles that end while busy are ignored and leave the sequence tracker idle.
- R9: A cycle whose address or data does not match the next expected step returns the tracker to idle without changing the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| ceN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output strobe |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data bus |
| dataOut | output | 8 | Read data or status byte |
| dataOutEn | output | 1 | High when dataOut drives the bus; low stands for high impedance |

## Verification
The bench builds the block with four sectors of 256 bytes and busy lengths of 8, 12 and 16 cycles. Small sectors let a sector erase be checked against bytes in its neighbours, and alias addresses 155h and 2AAh fall in different sectors. The short busy windows leave room for two status reads, an ignored write and one long read that crosses the end of busy. A complete run of program, erase and read-back sequences then stays well inside the cycle budget.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef struct packed {
    logic progStb;
    logic sectStb;
    logic chipStb;
  } arrCmd_t;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_SECT,
    OP_CHIP
  } opKind_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PROG,
    SQ_ERS1,
    SQ_ERS2,
    SQ_ERS3
  } seqState_t;

  localparam int KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_BYTE_A = 8'hAA;
  localparam logic [7:0] KEY_BYTE_B = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;

endpackage

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 200,
  parameter int CHIP_CYC = 800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output arrCmd_t           cmd,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic              busy,
  output logic [7:0]        status,
  output logic              seqIdle,
  output opKind_t           opKind
);

  localparam int MAX_AB  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CYC = (MAX_AB > CHIP_CYC) ? MAX_AB : CHIP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              wrNow, wrPrev, wrStart, wrEnd;
  logic              rdNow, rdPrev, rdEnd;
  logic [ADDR_W-1:0] addrHold;
  logic [KEY_W-1:0]  keyAddr;
  seqState_t         seq, seqNext;
  logic [CNT_W-1:0]  cnt;
  logic              launch;
  opKind_t           launchKind;
  logic              progBit7;
  logic              toggleBit;

  assign wrNow   = !ceN && !weN;
  assign rdNow   = !ceN && !oeN;
  assign wrStart = wrNow && !wrPrev;
  assign wrEnd   = !wrNow && wrPrev;
  assign rdEnd   = !rdNow && rdPrev;
  assign keyAddr = addrHold[KEY_W-1:0];

  always_comb begin
    seqNext    = seq;
    cmd        = '0;
    launch     = 1'b0;
    launchKind = OP_PROG;
    if (wrEnd && !busy) begin
      seqNext = SQ_IDLE;
      unique case (seq)
        SQ_IDLE:
          if (keyAddr == KEY_ADDR_A && dataIn == KEY_BYTE_A) seqNext = SQ_UNL1;
        SQ_UNL1:
          if (keyAddr == KEY_ADDR_B && dataIn == KEY_BYTE_B) seqNext = SQ_UNL2;
        SQ_UNL2:
          if (keyAddr == KEY_ADDR_A && dataIn == CMD_PROG) seqNext = SQ_PROG;
          else if (keyAddr == KEY_ADDR_A && dataIn == CMD_ERASE) seqNext = SQ_ERS1;
        SQ_PROG: begin
          cmd.progStb = 1'b1;
          launch      = 1'b1;
          launchKind  = OP_PROG;
        end
        SQ_ERS1:
          if (keyAddr == KEY_ADDR_A && dataIn == KEY_BYTE_A) seqNext = SQ_ERS2;
        SQ_ERS2:
          if (keyAddr == KEY_ADDR_B && dataIn == KEY_BYTE_B) seqNext = SQ_ERS3;
        SQ_ERS3:
          if (keyAddr == KEY_ADDR_A && dataIn == CMD_CHIP) begin
            cmd.chipStb = 1'b1;
            launch      = 1'b1;
            launchKind  = OP_CHIP;
          end else if (dataIn == CMD_SECT) begin
            cmd.sectStb = 1'b1;
            launch      = 1'b1;
            launchKind  = OP_SECT;
          end
        default: seqNext = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev    <= 1'b0;
      rdPrev    <= 1'b0;
      addrHold  <= '0;
      seq       <= SQ_IDLE;
      busy      <= 1'b0;
      cnt       <= '0;
      opKind    <= OP_PROG;
      progBit7  <= 1'b0;
      toggleBit <= 1'b0;
    end else begin
      wrPrev <= wrNow;
      rdPrev <= rdNow;
      seq    <= seqNext;
      if (wrStart) addrHold <= addr;
      if (launch) begin
        busy      <= 1'b1;
        opKind    <= launchKind;
        progBit7  <= dataIn[7];
        toggleBit <= 1'b0;
        unique case (launchKind)
          OP_PROG: cnt <= CNT_W'(PROG_CYC - 1);
          OP_SECT: cnt <= CNT_W'(SECT_CYC - 1);
          default: cnt <= CNT_W'(CHIP_CYC - 1);
        endcase
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
        if (rdEnd) toggleBit <= ~toggleBit;
      end
    end
  end

  assign opAddr  = addrHold;
  assign opData  = dataIn;
  assign seqIdle = (seq == SQ_IDLE);
  assign status  = {(opKind == OP_PROG) ? ~progBit7 : 1'b0, toggleBit, 6'b0};

endmodule

// File: rtl/pflash_array.sv
module pflash_array
  import pflash_pkg::*;
#(
  parameter int SECTOR_W = 10,
  parameter int SECTORS  = 2
) (
  input  logic                                  clk,
  input  logic                                  ceN,
  input  logic                                  oeN,
  input  arrCmd_t                               cmd,
  input  logic [SECTOR_W+$clog2(SECTORS)-1:0]   wrAddr,
  input  logic [7:0]                            wrData,
  input  logic [SECTOR_W+$clog2(SECTORS)-1:0]   rdAddr,
  input  logic                                  busy,
  input  logic [7:0]                            status,
  output logic [7:0]                            dataOut,
  output logic                                  dataOutEn
);

  localparam int ARR_W = SECTOR_W + $clog2(SECTORS);
  localparam int DEPTH = SECTORS << SECTOR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cmd.chipStb) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (cmd.sectStb) begin
      for (int i = 0; i < DEPTH; i++)
        if ((i >> SECTOR_W) == int'(wrAddr[ARR_W-1:SECTOR_W])) mem[i] <= 8'hFF;
    end else if (cmd.progStb) begin
      mem[wrAddr] <= mem[wrAddr] & wrData;
    end
  end

  assign dataOut   = busy ? status : mem[rdAddr];
  assign dataOutEn = !ceN && !oeN;

endmodule

// File: rtl/pflash_cmd_decoder.sv
module pflash_cmd_decoder
  import pflash_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int SECTOR_W = 10,
  parameter int SECTORS  = 2,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 200,
  parameter int CHIP_CYC = 800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn
);

  localparam int ARR_W = SECTOR_W + $clog2(SECTORS);

  arrCmd_t           cmd;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic              busy;
  logic [7:0]        status;
  logic              seqIdle;
  opKind_t           opKind;
  logic              eraseOp;

  pflash_ctrl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .cmd(cmd), .opAddr(opAddr), .opData(opData),
    .busy(busy), .status(status), .seqIdle(seqIdle), .opKind(opKind)
  );

  pflash_array #(.SECTOR_W(SECTOR_W), .SECTORS(SECTORS)) array (
    .clk(clk), .ceN(ceN), .oeN(oeN), .cmd(cmd),
    .wrAddr(opAddr[ARR_W-1:0]), .wrData(opData), .rdAddr(addr[ARR_W-1:0]),
    .busy(busy), .status(status), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  assign eraseOp = (opKind != OP_PROG);

endmodule

// File: rtl/pflash_cmd_checker.sv
module pflash_cmd_checker #(
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 200,
  parameter int CHIP_CYC = 800
) (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       weN,
  input logic [7:0] dataOut,
  input logic       dataOutEn,
  input logic       busy,
  input logic       seqIdle,
  input logic       eraseOp
);

  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1;
    else busyRun <= '0;
  end

  // R4: busy only starts right after a write cycle has ended
  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(ceN || weN) && $past(!ceN && !weN, 2)));

  // R4: the busy window has one of the configured lengths
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == PROG_CYC || busyRun == SECT_CYC || busyRun == CHIP_CYC));

  // R7: toggle bit steady within one read
  p_toggle_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataOutEn && $past(busy) && $past(dataOutEn)) |-> $stable(dataOut[6]));

  // R7: erase status shows bit 7 low
  p_erase_dq7_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && eraseOp && dataOutEn) |-> !dataOut[7]);

  // R8: no sequence progress while busy
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> seqIdle);

endmodule

bind pflash_cmd_decoder pflash_cmd_checker #(
  .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
) chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .dataOut(dataOut),
  .dataOutEn(dataOutEn), .busy(busy), .seqIdle(seqIdle), .eraseOp(eraseOp)
);

// File: tb/pflash_cmd_decoder_test.sv
module pflash_cmd_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 15;
  localparam int PROG_CYC = 8;
  localparam int SECT_CYC = 12;
  localparam int CHIP_CYC = 16;

  // vector: {addr[15:0], data[7:0], expected read-back[7:0]}
  localparam logic [31:0] VEC [5] = '{
    {16'h0010, 8'hF0, 8'hF0},
    {16'h0010, 8'h3C, 8'h30},
    {16'h03FF, 8'h00, 8'h00},
    {16'h0305, 8'hA5, 8'hA5},
    {16'h0101, 8'h7E, 8'h7E}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dataIn = '0;
  logic [7:0]        dataOut;
  logic              dataOutEn;
  int total = 0;
  int bad = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pflash_cmd_decoder #(
    .ADDR_W(ADDR_W), .SECTOR_W(8), .SECTORS(4),
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; dataIn = d; ceN = 1'b0;
    @(negedge clk); weN = 1'b0;
    @(negedge clk);
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readByte(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); v = dataOut;
    oeN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlockProg();
    busWrite(15'h5555, 8'hAA); busWrite(15'h2AAA, 8'h55); busWrite(15'h5555, 8'hA0);
  endtask

  task automatic unlockErase();
    busWrite(15'h5555, 8'hAA); busWrite(15'h2AAA, 8'h55); busWrite(15'h5555, 8'h80);
    busWrite(15'h5555, 8'hAA); busWrite(15'h2AAA, 8'h55);
  endtask

  task automatic finishReport();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishReport();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset dataOutEn", {7'b0, dataOutEn}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R2 output enable gating
    ceN = 1'b0; @(negedge clk);
    check("R2 ce only", {7'b0, dataOutEn}, 8'h00);
    ceN = 1'b1; oeN = 1'b0; @(negedge clk);
    check("R2 oe only", {7'b0, dataOutEn}, 8'h00);
    ceN = 1'b0; @(negedge clk);
    check("R2 both low", {7'b0, dataOutEn}, 8'h01);
    ceN = 1'b1; oeN = 1'b1; @(negedge clk);

    // R6 chip erase with status read (R7)
    unlockErase(); busWrite(15'h5555, 8'h10);
    readByte(15'h0000, rd); check("R7 chip erase status", rd, 8'h00);
    repeat (CHIP_CYC + 2) @(negedge clk);
    readByte(15'h0000, rd); check("R6 byte 000", rd, 8'hFF);
    readByte(15'h0155, rd); check("R6 byte 155", rd, 8'hFF);
    readByte(15'h03FF, rd); check("R6 byte 3FF", rd, 8'hFF);

    // R3 program vectors
    for (int i = 0; i < 5; i++) begin
      unlockProg(); busWrite(VEC[i][30:16], VEC[i][15:8]);
      repeat (PROG_CYC + 2) @(negedge clk);
      readByte(VEC[i][30:16], rd); check("R3 program vector", rd, VEC[i][7:0]);
    end

    // R1 later fall latches address, earlier rise latches data
    unlockProg();
    addr = 15'h00C0; dataIn = 8'h0F; weN = 1'b0;
    @(negedge clk); addr = 15'h0020;
    @(negedge clk); ceN = 1'b0;
    @(negedge clk); addr = 15'h00C1;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk); dataIn = 8'h00;
    @(negedge clk); weN = 1'b1;
    repeat (PROG_CYC + 2) @(negedge clk);
    readByte(15'h0020, rd); check("R1 target byte", rd, 8'h0F);
    readByte(15'h00C0, rd); check("R1 early address unused", rd, 8'hFF);
    readByte(15'h00C1, rd); check("R1 late address unused", rd, 8'hFF);

    // R1 weN pulse with ceN high is no cycle
    unlockProg();
    addr = 15'h0030; dataIn = 8'h00;
    weN = 1'b0; @(negedge clk); @(negedge clk); weN = 1'b1; @(negedge clk);
    busWrite(15'h0031, 8'h11);
    repeat (PROG_CYC + 2) @(negedge clk);
    readByte(15'h0030, rd); check("R1 ce high ignored", rd, 8'hFF);
    readByte(15'h0031, rd); check("R1 program after ce-high pulse", rd, 8'h11);

    // R7 program status and toggle
    unlockProg(); busWrite(15'h0040, 8'h5A);
    readByte(15'h0040, rd); check("R7 first status read", rd, 8'h80);
    readByte(15'h0040, rd); check("R7 second status read", rd, 8'hC0);
    repeat (PROG_CYC + 2) @(negedge clk);
    readByte(15'h0040, rd); check("R3 byte after status", rd, 8'h5A);

    // R4 one long read across the end of busy
    unlockProg(); busWrite(15'h0060, 8'h3C);
    addr = 15'h0060; ceN = 1'b0; oeN = 1'b0;
    for (int k = 1; k <= PROG_CYC; k++) begin
      @(negedge clk);
      if (k == PROG_CYC - 2) check("R4 status near end", dataOut, 8'h80);
      if (k == PROG_CYC - 1) check("R4 data after busy", dataOut, 8'h3C);
    end
    oeN = 1'b1; ceN = 1'b1; @(negedge clk);

    // R9 wrong command byte and wrong address
    busWrite(15'h5555, 8'hAA); busWrite(15'h2AAA, 8'h55); busWrite(15'h5555, 8'h90);
    busWrite(15'h0070, 8'h00);
    repeat (PROG_CYC + 2) @(negedge clk);
    readByte(15'h0070, rd); check("R9 wrong command", rd, 8'hFF);
    busWrite(15'h1234, 8'hAA); busWrite(15'h2AAA, 8'h55); busWrite(15'h5555, 8'hA0);
    busWrite(15'h0071, 8'h00);
    repeat (PROG_CYC + 2) @(negedge clk);
    readByte(15'h0071, rd); check("R9 wrong address", rd, 8'hFF);
    unlockErase(); busWrite(15'h0100, 8'h20);
    repeat (SECT_CYC + 2) @(negedge clk);
    readByte(15'h0101, rd); check("R9 wrong erase byte", rd, 8'h7E);

    // R5 sector erase, R7 status, R8 write ignored while busy
    unlockErase(); busWrite(15'h00A0, 8'h30);
    readByte(15'h0010, rd); check("R7 sector status first", rd, 8'h00);
    readByte(15'h0010, rd); check("R7 sector status second", rd, 8'h40);
    busWrite(15'h5555, 8'hAA);
    repeat (SECT_CYC + 2) @(negedge clk);
    readByte(15'h0010, rd); check("R5 sector0 byte 010", rd, 8'hFF);
    readByte(15'h0020, rd); check("R5 sector0 byte 020", rd, 8'hFF);
    readByte(15'h0101, rd); check("R5 sector1 kept", rd, 8'h7E);
    readByte(15'h0305, rd); check("R5 sector3 kept", rd, 8'hA5);
    busWrite(15'h2AAA, 8'h55); busWrite(15'h5555, 8'hA0); busWrite(15'h0050, 8'h00);
    repeat (PROG_CYC + 2) @(negedge clk);
    readByte(15'h0050, rd); check("R8 write during busy ignored", rd, 8'hFF);

    // R6 second chip erase clears programmed bytes
    unlockErase(); busWrite(15'h5555, 8'h10);
    repeat (CHIP_CYC + 2) @(negedge clk);
    readByte(15'h0305, rd); check("R6 byte 305 cleared", rd, 8'hFF);
    readByte(15'h03FF, rd); check("R6 byte 3FF cleared", rd, 8'hFF);

    finishReport();
  end

endmodule